// File: doc/BRIEF.md
# Folded-Quadrant Phase Meter

This block measures the phase difference between two square waves, a reference on `a_in` and a second channel on `b_in`, and reports it in tenths of a degree over the full circle from -180.0 to +180.0 degrees. Both inputs are sampled on the system clock through a synchronizer. The timing core only reads lags inside a quarter cycle. A quadrant stage therefore decides, once per reference period, whether the phase magnitude is at least 90 degrees. When it is, channel B is inverted before it reaches the timing core, and a correction stage afterwards moves the folded reading by half a turn to restore the true angle.

The interval from each reference rising edge to the next rising edge of the (possibly inverted) second channel is divided by the measured reference period. A serial divider does this division, and its result is corrected and presented as a signed word with a one-cycle valid strobe. The quadrant flag is visible on its own output. It changes only at a reference rising edge, and a period in which the inversion changed at the start is discarded. Both inputs are expected to have the same frequency and a duty cycle of about 50 %.

Top module: `phase_fold_meter`

## Requirements
- R1: While reset is applied and after it is released, `phase_o` is 0, `valid_o` is low and `quad_o` is high.
- R2: `quad_o` is high when fewer than half of the clock cycles in the previous complete reference period had `a_in` different from `b_in`, and low otherwise. It takes a new value only in the cycle after a reference rising edge, and the first update happens at the second reference rising edge after reset.
- R3: `valid_o` is a single-cycle pulse. It is never high in two consecutive cycles.
- R4: No `valid_o` pulse occurs before the third reference rising edge after reset, which is the end of two complete periods.
- R5: When the lag of channel B is below a quarter period in magnitude, `phase_o` at `valid_o` equals lag_cycles*3600/period_cycles with the magnitude truncated toward zero. The value is positive when B lags A and negative when B leads A.
- R6: When the lag magnitude is above a quarter period, `phase_o` still gives the true signed angle. 1800 is added when the folded reading is zero or negative, and subtracted when it is positive.
- R7: A lag of exactly half a period reads +1800. A lag of exactly a quarter period reads +900, a lead of exactly a quarter period reads -900, and both give `quad_o` low.
- R8: A reference period that contains no rising edge of the (possibly inverted) channel B produces no `valid_o` pulse.
- R9: A period at whose start `quad_o` changed produces no `valid_o` pulse. With a lag above a quarter period, the first pulse after reset therefore follows the fourth reference rising edge.
- R10: `phase_o` changes only in a cycle where `valid_o` is high, and it always lies between -1800 and +1800.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| a_in | input | 1 | Reference square wave, asynchronous |
| b_in | input | 1 | Measured square wave, asynchronous |
| phase_o | output | PH_W (12) | Signed phase in tenths of a degree, positive when B lags |
| quad_o | output | 1 | High when the phase magnitude is below 90 degrees |
| valid_o | output | 1 | One-cycle strobe when a new phase word is presented |

## Verification
The bound checker watches four properties on every cycle. It checks that the valid strobe lasts a single cycle, that the quadrant flag stays still except right after a reference rising edge, that the phase word moves only together with the strobe and stays within the signed half-turn range, and that no strobe appears before two complete reference periods. The numeric correctness of the reading can only be shown by the directed scenarios. These cover in-range lags and leads, truncation on a period that does not divide evenly, folded lags beyond a quarter turn, and the exact quarter- and half-turn boundaries. The scenarios also show two gaps in the strobe: the extra period discarded after the inversion changes, and the silence when channel B never rises.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  // Tenths of a degree in a full turn and in half a turn.
  localparam int unsigned TENTHS_FULL = 3600;
  localparam int unsigned TENTHS_HALF = 1800;

  // Bits needed to hold TENTHS_FULL.
  localparam int unsigned SCALE_W = 12;

  typedef enum logic {
    SC_IDLE = 1'b0,
    SC_RUN  = 1'b1
  } sc_state_e;

endpackage

// File: rtl/pfm_sync.sv
// Multi-bit level synchronizer; each bit is independent.
module pfm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb stg_d = din;
    end else begin : g_chain
      always_comb stg_d = {stg_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q <= stg_d;
    end
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pfm_quadrant.sv
// Measures the fraction of a reference period during which the two
// channels disagree and decides whether the magnitude is below 90 degrees.
module pfm_quadrant #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_rise,
  input  logic             a_lvl,
  input  logic             b_lvl,
  input  logic [CNT_W-1:0] per_now,
  output logic             quad,
  output logic             flip
);

  localparam logic [CNT_W-1:0] X_MAX = '1;

  logic [CNT_W-1:0] xcnt_q, xcnt_d;
  logic             armed_q, armed_d;
  logic             quad_q, quad_d;
  logic             diff;
  logic             q_meas;
  logic             upd;

  always_comb begin
    diff   = a_lvl ^ b_lvl;
    // Disagreement below half the period means |phase| < 90 degrees.
    q_meas = {xcnt_q, 1'b0} < {1'b0, per_now};
    upd    = a_rise & armed_q;
    flip   = upd & (q_meas != quad_q);

    if (a_rise) begin
      xcnt_d = CNT_W'(diff);
    end else if (xcnt_q == X_MAX) begin
      xcnt_d = xcnt_q;
    end else begin
      xcnt_d = xcnt_q + CNT_W'(diff);
    end

    armed_d = armed_q | a_rise;
    quad_d  = upd ? q_meas : quad_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt_q  <= '0;
      armed_q <= 1'b0;
      quad_q  <= 1'b1;
    end else begin
      xcnt_q  <= xcnt_d;
      armed_q <= armed_d;
      quad_q  <= quad_d;
    end
  end

  assign quad = quad_q;

endmodule

// File: rtl/pfm_interval.sv
// Start/stop timing core: the reference edge starts the count, the folded
// second channel's edge stops it. Snapshots are taken at each reference edge.
module pfm_interval #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_rise,
  input  logic             bf_lvl,
  output logic [CNT_W-1:0] per_now,
  output logic [CNT_W-1:0] snap_per,
  output logic [CNT_W-1:0] snap_dly,
  output logic             snap_seen
);

  localparam logic [CNT_W-1:0] C_MAX = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] dly_q, dly_d;
  logic             seen_q, seen_d;
  logic             bfp_q;
  logic             bf_rise;
  logic [CNT_W-1:0] sper_q, sper_d;
  logic [CNT_W-1:0] sdly_q, sdly_d;
  logic             sseen_q, sseen_d;

  always_comb begin
    bf_rise = bf_lvl & ~bfp_q;
    per_now = cnt_q + CNT_W'(1);

    if (a_rise) begin
      cnt_d = '0;
    end else if (cnt_q == C_MAX) begin
      cnt_d = cnt_q;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end

    dly_d  = dly_q;
    seen_d = seen_q;
    if (a_rise) begin
      seen_d = bf_rise;
      if (bf_rise) begin
        dly_d = '0;
      end
    end else if (bf_rise) begin
      dly_d  = cnt_q + CNT_W'(1);
      seen_d = 1'b1;
    end

    sper_d  = a_rise ? per_now : sper_q;
    sdly_d  = a_rise ? dly_q   : sdly_q;
    sseen_d = a_rise ? seen_q  : sseen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      dly_q   <= '0;
      seen_q  <= 1'b0;
      bfp_q   <= 1'b0;
      sper_q  <= '0;
      sdly_q  <= '0;
      sseen_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      dly_q   <= dly_d;
      seen_q  <= seen_d;
      bfp_q   <= bf_lvl;
      sper_q  <= sper_d;
      sdly_q  <= sdly_d;
      sseen_q <= sseen_d;
    end
  end

  assign snap_per  = sper_q;
  assign snap_dly  = sdly_q;
  assign snap_seen = sseen_q;

endmodule

// File: rtl/pfm_scale.sv
// Converts an edge delay and a period into signed tenths of a degree with a
// serial restoring divider (one quotient bit per cycle).
module pfm_scale
  import pfm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int PH_W  = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CNT_W-1:0]       per,
  input  logic [CNT_W-1:0]       dly,
  output logic                   done,
  output logic signed [PH_W-1:0] folded
);

  localparam int NUM_W  = CNT_W + SCALE_W;
  localparam int STEP_W = $clog2(NUM_W);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_W - 1);

  sc_state_e         st_q, st_d;
  logic [NUM_W-1:0]  num_q, num_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [PH_W-1:0]   quo_q, quo_d;
  logic [CNT_W-1:0]  per_q, per_d;
  logic              neg_q, neg_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              done_q, done_d;

  logic              neg_in;
  logic [CNT_W-1:0]  mag_in;
  logic [NUM_W-1:0]  prod_in;
  logic [CNT_W:0]    rem_sh;
  logic              ge;
  logic signed [PH_W-1:0] quo_s;

  always_comb begin
    // A stop edge in the second half of the period is a lead.
    neg_in  = {dly, 1'b0} >= {1'b0, per};
    mag_in  = neg_in ? (per - dly) : dly;
    prod_in = NUM_W'(mag_in) * NUM_W'(TENTHS_FULL);

    rem_sh = {rem_q, num_q[NUM_W-1]};
    ge     = rem_sh >= {1'b0, per_q};

    st_d   = st_q;
    num_d  = num_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    per_d  = per_q;
    neg_d  = neg_q;
    step_d = step_q;
    done_d = 1'b0;

    case (st_q)
      SC_IDLE: begin
        if (start) begin
          st_d   = SC_RUN;
          num_d  = prod_in;
          rem_d  = '0;
          quo_d  = '0;
          per_d  = per;
          neg_d  = neg_in;
          step_d = '0;
        end
      end
      SC_RUN: begin
        num_d = {num_q[NUM_W-2:0], 1'b0};
        rem_d = ge ? CNT_W'(rem_sh - {1'b0, per_q}) : rem_sh[CNT_W-1:0];
        quo_d = {quo_q[PH_W-2:0], ge};
        if (step_q == LAST) begin
          st_d   = SC_IDLE;
          done_d = 1'b1;
        end else begin
          step_d = step_q + STEP_W'(1);
        end
      end
      default: st_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SC_IDLE;
      num_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      per_q  <= '0;
      neg_q  <= 1'b0;
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      num_q  <= num_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      per_q  <= per_d;
      neg_q  <= neg_d;
      step_q <= step_d;
      done_q <= done_d;
    end
  end

  assign quo_s  = quo_q;
  assign folded = neg_q ? -quo_s : quo_s;
  assign done   = done_q;

endmodule

// File: rtl/phase_fold_meter.sv
module phase_fold_meter
  import pfm_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int PH_W        = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   a_in,
  input  logic                   b_in,
  output logic signed [PH_W-1:0] phase_o,
  output logic                   quad_o,
  output logic                   valid_o
);

  localparam logic signed [PH_W:0] HALF_S = (PH_W+1)'(TENTHS_HALF);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rsync_q[1];

  logic [1:0]       lvl;
  logic             a_lvl, b_lvl, a_prev_q, a_rise;
  logic [CNT_W-1:0] per_now;
  logic             quad_q, q_flip;
  logic             bf_lvl;
  logic [CNT_W-1:0] snap_per, snap_dly;
  logic             snap_seen;
  logic             go;
  logic             sc_done;
  logic signed [PH_W-1:0] folded;

  pfm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   ({b_in, a_in}),
    .dout  (lvl)
  );

  assign a_lvl  = lvl[0];
  assign b_lvl  = lvl[1];
  assign a_rise = a_lvl & ~a_prev_q;

  pfm_quadrant #(.CNT_W(CNT_W)) u_quad (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .a_rise  (a_rise),
    .a_lvl   (a_lvl),
    .b_lvl   (b_lvl),
    .per_now (per_now),
    .quad    (quad_q),
    .flip    (q_flip)
  );

  // Channel B is passed as is below 90 degrees, inverted above.
  assign bf_lvl = b_lvl ^ ~quad_q;

  pfm_interval #(.CNT_W(CNT_W)) u_intv (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .a_rise    (a_rise),
    .bf_lvl    (bf_lvl),
    .per_now   (per_now),
    .snap_per  (snap_per),
    .snap_dly  (snap_dly),
    .snap_seen (snap_seen)
  );

  pfm_scale #(.CNT_W(CNT_W), .PH_W(PH_W)) u_scale (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .start  (go),
    .per    (snap_per),
    .dly    (snap_dly),
    .done   (sc_done),
    .folded (folded)
  );

  // Period bookkeeping and fold correction.
  logic [1:0]             rises_q, rises_d;
  logic                   dirty_q, dirty_d;
  logic                   start_q, start_d;
  logic                   inv_q, inv_d;
  logic signed [PH_W-1:0] phase_q, phase_d;
  logic                   valid_q, valid_d;
  logic signed [PH_W:0]   fx, corr;

  always_comb begin
    rises_d = (a_rise && rises_q != 2'd3) ? rises_q + 2'd1 : rises_q;
    dirty_d = a_rise ? q_flip : dirty_q;
    start_d = a_rise & (rises_q >= 2'd2) & ~dirty_q;
    inv_d   = a_rise ? ~quad_q : inv_q;
    go      = start_q & snap_seen;

    fx = {folded[PH_W-1], folded};
    if (!inv_q) begin
      corr = fx;
    end else if (fx <= 0) begin
      corr = fx + HALF_S;
    end else begin
      corr = fx - HALF_S;
    end

    phase_d = sc_done ? PH_W'(corr) : phase_q;
    valid_d = sc_done;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      a_prev_q <= 1'b0;
      rises_q  <= '0;
      dirty_q  <= 1'b0;
      start_q  <= 1'b0;
      inv_q    <= 1'b0;
      phase_q  <= '0;
      valid_q  <= 1'b0;
    end else begin
      a_prev_q <= a_lvl;
      rises_q  <= rises_d;
      dirty_q  <= dirty_d;
      start_q  <= start_d;
      inv_q    <= inv_d;
      phase_q  <= phase_d;
      valid_q  <= valid_d;
    end
  end

  assign phase_o = phase_q;
  assign quad_o  = quad_q;
  assign valid_o = valid_q;

endmodule

module phase_fold_meter_chk #(
  parameter int PH_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   a_rise,
  input logic                   valid,
  input logic                   quad,
  input logic signed [PH_W-1:0] phase
);

  logic [1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (a_rise && seen_q != 2'd3) begin
      seen_q <= seen_q + 2'd1;
    end
  end

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R2
  quad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rise |=> $stable(quad));

  // R10
  phase_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(phase));

  // R10
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase >= -1800) && (phase <= 1800));

  // R4
  early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (seen_q == 2'd3));

endmodule

bind phase_fold_meter phase_fold_meter_chk #(.PH_W(PH_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_core_n),
  .a_rise (a_rise),
  .valid  (valid_o),
  .quad   (quad_o),
  .phase  (phase_o)
);

// File: tb/phase_fold_meter_test.sv
module phase_fold_meter_test;

  logic              clk;
  logic              rst_n;
  logic              a_in;
  logic              b_in;
  logic signed [11:0] phase_o;
  logic              quad_o;
  logic              valid_o;

  int checks;
  int failures;

  phase_fold_meter uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .b_in    (b_in),
    .phase_o (phase_o),
    .quad_o  (quad_o),
    .valid_o (valid_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    a_in  = 1'b0;
    b_in  = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // R1: state during and after reset.
  task automatic t_reset_state();
    rst_n = 1'b0;
    a_in  = 1'b0;
    b_in  = 1'b0;
    repeat (3) @(negedge clk);
    check(phase_o == 12'sd0, "R1", "phase in reset", phase_o, 0);
    check(valid_o == 1'b0, "R1", "valid in reset", valid_o, 0);
    check(quad_o == 1'b1, "R1", "quad in reset", quad_o, 1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(phase_o == 12'sd0 && valid_o == 1'b0, "R1", "phase/valid after release",
          phase_o, 0);
    check(quad_o == 1'b1, "R1", "quad after release", quad_o, 1);
  endtask

  // Drives seven periods of a per-cycle square wave with B lagging by lag
  // cycles (negative lag = lead) and checks every phase word that appears.
  task automatic run_case(input int per, input int lag, input int exp_ph,
                          input bit exp_q, input int min_first, input string req);
    int nval  = 0;
    int bad   = 0;
    int first = -1;
    int badv  = 0;
    do_reset();
    for (int t = 0; t < 7 * per; t++) begin
      @(negedge clk);
      if (valid_o) begin
        if (first < 0) first = t;
        nval++;
        if (int'(phase_o) != exp_ph) begin
          bad++;
          badv = int'(phase_o);
        end
      end
      a_in = (t % per) < (per / 2);
      b_in = ((((t - lag) % per) + per) % per) < (per / 2);
    end
    check(nval >= 2, req, "valid pulse count", nval, 2);
    check(bad == 0, req, "phase word", (bad == 0) ? exp_ph : badv, exp_ph);
    check(quad_o == exp_q, req, "quadrant flag", quad_o, exp_q);
    check(first > min_first, req, "first valid cycle", first, min_first + 1);
  endtask

  // R8: channel B never rises, so no phase word may appear.
  task automatic t_no_b_edge();
    int nval = 0;
    int per  = 360;
    do_reset();
    for (int t = 0; t < 6 * per; t++) begin
      @(negedge clk);
      if (valid_o) nval++;
      a_in = (t % per) < (per / 2);
      b_in = 1'b0;
    end
    check(nval == 0, "R8", "valid pulses with B idle", nval, 0);
    check(phase_o == 12'sd0, "R8", "phase word untouched", phase_o, 0);
    // R2: A and B disagree half the time, so the flag drops.
    check(quad_o == 1'b0, "R2", "quad with B idle", quad_o, 0);
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    rst_n    = 1'b0;
    a_in     = 1'b0;
    b_in     = 1'b0;

    t_reset_state();

    // R5 and R4: in-range lags and leads, period 360 cycles = 10 tenths/cycle.
    run_case(360,   0,     0, 1'b1, 2 * 360, "R5");
    run_case(360,  30,   300, 1'b1, 2 * 360, "R4");
    run_case(360, -45,  -450, 1'b1, 2 * 360, "R5");
    run_case(360,  89,   890, 1'b1, 2 * 360, "R2");
    // R5: truncation toward zero, 7*3600/270 = 93.3.
    run_case(270,   7,    93, 1'b1, 2 * 270, "R5");
    run_case(270,  -7,   -93, 1'b1, 2 * 270, "R5");
    // R6 and R9: folded readings; the period after the flag change is dropped.
    run_case(360, 120,  1200, 1'b0, 3 * 360, "R9");
    run_case(360, -120, -1200, 1'b0, 3 * 360, "R6");
    run_case(200, -70,  -1260, 1'b0, 3 * 200, "R6");
    // R7: exact half and quarter turns.
    run_case(360, 180,  1800, 1'b0, 3 * 360, "R7");
    run_case(360,  90,   900, 1'b0, 3 * 360, "R7");
    run_case(360, -90,  -900, 1'b0, 3 * 360, "R7");

    t_no_b_edge();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule